// File: doc/BRIEF.md
# Shared-Bus Flash and Pseudo-SRAM Host Controller

This block sits on the host side of a package that holds a NOR-type flash die and a pseudo-SRAM die on one common address and data bus. It takes single-word read and write requests over a valid/ready handshake. Each request carries a target select (flash or pseudo-SRAM), a 23-bit word address, write data and two active-high byte enables. The block turns each request into an asynchronous bus cycle: the chip enable of the chosen die, its output or write enable, the flash address-latch strobe, and the pseudo-SRAM byte-lane strobes. The result comes back over a valid/ready response channel.

The block also owns two level-controlled pins that the host requests through inputs. One is the pseudo-SRAM sleep pin: held low, the die enters deep power-down. The other is the flash hardware reset. Both pins change only while no bus cycle is in flight. While either die is unavailable, a request to it is answered at once with an error flag and no bus cycle. Read strobe widths are set per die by access-time parameters in clock cycles. The asynchronous reset is released through a two-stage synchronizer.

Top module: `dmem_bus_ctrl`

## Requirements
- R1: The flash chip enable is never active while the pseudo-SRAM primary enable is active and its sleep pin is high. A die's chip enable only becomes active after a clock cycle in which the other die's enable was inactive.
- R2: Flash cycles present all 23 address bits. Pseudo-SRAM cycles drive address bit 22 low and are decoded from bits 21:0 only, so two addresses that differ only in bit 22 reach the same pseudo-SRAM word.
- R3: During a pseudo-SRAM cycle the upper lane strobe (data 15:8) is low exactly when request enable bit 1 is set, and the lower lane strobe (data 7:0) is low exactly when bit 0 is set. A lane that is not enabled is neither written nor returned; it reads back as 0. Flash cycles ignore the byte enables and move the full word.
- R4: A read holds the output enable low for exactly FL_ACC (flash) or PS_ACC (pseudo-SRAM) clock cycles. The read data is captured at the clock edge that ends the last of those cycles.
- R5: A flash cycle opens with one cycle where chip enable falls and the latch strobe is low. The latch strobe rises before output or write enable is asserted.
- R6: On a write, write enable rises while chip enable is still low. Address and write data are unchanged across that rise.
- R7: Raising the sleep request drives the pseudo-SRAM sleep pin low only while its primary enable is high. Lowering the request restores normal access.
- R8: The flash reset pin is low from system reset until the first idle cycle after release, and whenever the reset request is high. No flash strobe is active while it is low.
- R9: A request to a sleeping pseudo-SRAM, or to a flash held in reset, returns a response with the error flag set and read data 0. No chip enable becomes active for it.
- R10: The request ready output is high only when the block is idle and no power-pin change is pending. A response stays valid with unchanged data and error flag until response ready is seen.
- R11: During reset both chip enables, all output, write and lane strobes, and the latch strobe are inactive (high). The response is not valid and the pseudo-SRAM sleep pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_tgt | input | 1 | Target: 0 flash, 1 pseudo-SRAM |
| req_wr | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Target unavailable |
| ps_sleep | input | 1 | Request pseudo-SRAM deep power-down |
| fl_reset | input | 1 | Request flash hardware reset |
| mem_addr | output | ADDR_W | Shared address bus |
| mem_dq_o | output | 16 | Shared data bus, driven value |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_i | input | 16 | Shared data bus, received value |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_adv_n | output | 1 | Flash address latch strobe, transparent low |
| fl_rst_n | output | 1 | Flash hardware reset, active low |
| ps_ce1_n | output | 1 | Pseudo-SRAM primary enable, active low |
| ps_ce2 | output | 1 | Pseudo-SRAM sleep pin, low for deep power-down |
| ps_oe_n | output | 1 | Pseudo-SRAM output enable, active low |
| ps_we_n | output | 1 | Pseudo-SRAM write enable, active low |
| ps_ub_n | output | 1 | Pseudo-SRAM upper lane strobe, active low |
| ps_lb_n | output | 1 | Pseudo-SRAM lower lane strobe, active low |

## Verification
The bench builds the block with FL_ACC = 3 and PS_ACC = 2 instead of the defaults 4 and 3. The two dies therefore have different strobe widths, and a counter that loads the wrong die's value shows up as an output enable of the wrong length. Its bus models return garbage until the output enable has been low for the parameterized count. An early sample, or a lane that is not masked, shows up in the read data. The address width stays at 23, so bit 22 separates flash words while the pseudo-SRAM model must alias them.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;

  typedef enum logic {
    TGT_FLASH = 1'b0,
    TGT_PSRAM = 1'b1
  } tgt_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_END    = 3'd3,
    ST_RESP   = 3'd4
  } seq_st_t;
endpackage

// File: rtl/dmem_timer.sv
module dmem_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (run && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = load_val;
    else if (run && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dmem_pwr.sv
module dmem_pwr (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic ps_sleep,
  input  logic fl_reset,
  output logic ps_ce2,
  output logic fl_rst_n,
  output logic busy
);
  logic ps_ce2_d, fl_rst_n_d, upd_en;

  // a pin differs from what its request asks for
  assign busy   = (ps_ce2 == ps_sleep) || (fl_rst_n == fl_reset);
  assign upd_en = idle && busy;

  always_comb begin
    ps_ce2_d   = !ps_sleep;
    fl_rst_n_d = !fl_reset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_ce2   <= 1'b1;
      fl_rst_n <= 1'b0;
    end else if (upd_en) begin
      ps_ce2   <= ps_ce2_d;
      fl_rst_n <= fl_rst_n_d;
    end
  end
endmodule

// File: rtl/dmem_seq.sv
module dmem_seq
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int FL_ACC = 4,
  parameter int PS_ACC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_tgt,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic              fl_up,
  input  logic              ps_up,
  input  logic              pwr_busy,
  output logic              idle,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic              fl_adv_n,
  output logic              ps_ce1_n,
  output logic              ps_oe_n,
  output logic              ps_we_n,
  output logic              ps_ub_n,
  output logic              ps_lb_n
);
  localparam int MAX_ACC = (FL_ACC > PS_ACC) ? FL_ACC : PS_ACC;
  localparam int CNT_W   = $clog2(MAX_ACC + 1);
  localparam logic [CNT_W-1:0] FL_LOAD = CNT_W'(FL_ACC - 1);
  localparam logic [CNT_W-1:0] PS_LOAD = CNT_W'(PS_ACC - 1);

  seq_st_t           st_q, st_d;
  tgt_t              tgt_q;
  logic              wr_q, err_q, err_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d, rd_word;
  logic [1:0]        be_q;
  logic              accept, unavail, cap_en, rd_cap, acc_done, act, on_fl, on_ps;

  assign idle      = (st_q == ST_IDLE);
  assign req_ready = idle && !pwr_busy;
  assign accept    = req_valid && req_ready;
  assign unavail   = (tgt_t'(req_tgt) == TGT_PSRAM) ? !ps_up : !fl_up;

  dmem_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (st_q == ST_SETUP),
    .load_val ((tgt_q == TGT_PSRAM) ? PS_LOAD : FL_LOAD),
    .run      (st_q == ST_STROBE),
    .zero     (acc_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept) st_d = unavail ? ST_RESP : ST_SETUP;
      ST_SETUP:  st_d = ST_STROBE;
      ST_STROBE: if (acc_done) st_d = ST_END;
      ST_END:    st_d = ST_RESP;
      ST_RESP:   if (rsp_ready) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  // read word with disabled pseudo-SRAM lanes forced to zero
  always_comb begin
    rd_word = mem_dq_i;
    if (tgt_q == TGT_PSRAM) begin
      if (!be_q[1]) rd_word[DATA_W-1:LANE_W] = '0;
      if (!be_q[0]) rd_word[LANE_W-1:0]      = '0;
    end
  end

  assign rd_cap  = (st_q == ST_STROBE) && acc_done && !wr_q;
  assign cap_en  = accept || rd_cap;
  assign err_d   = accept ? unavail : err_q;
  assign rdata_d = accept ? '0 : rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= TGT_FLASH;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      tgt_q   <= tgt_t'(req_tgt);
      wr_q    <= req_wr;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (cap_en) begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign act   = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_END);
  assign on_fl = act && (tgt_q == TGT_FLASH);
  assign on_ps = act && (tgt_q == TGT_PSRAM);

  assign fl_ce_n  = !on_fl;
  assign fl_adv_n = !(on_fl && (st_q == ST_SETUP));
  assign fl_oe_n  = !(on_fl && (st_q == ST_STROBE) && !wr_q);
  assign fl_we_n  = !(on_fl && (st_q == ST_STROBE) && wr_q);
  assign ps_ce1_n = !on_ps;
  assign ps_oe_n  = !(on_ps && (st_q == ST_STROBE) && !wr_q);
  assign ps_we_n  = !(on_ps && (st_q == ST_STROBE) && wr_q);
  assign ps_ub_n  = !(on_ps && be_q[1]);
  assign ps_lb_n  = !(on_ps && be_q[0]);

  assign mem_addr  = (tgt_q == TGT_PSRAM) ? {1'b0, addr_q[ADDR_W-2:0]} : addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = act && wr_q;

  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;
endmodule

// File: rtl/dmem_bus_ctrl.sv
module dmem_bus_ctrl #(
  parameter int ADDR_W = 23,
  parameter int FL_ACC = 4,
  parameter int PS_ACC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_tgt,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic              ps_sleep,
  input  logic              fl_reset,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_i,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic              fl_adv_n,
  output logic              fl_rst_n,
  output logic              ps_ce1_n,
  output logic              ps_ce2,
  output logic              ps_oe_n,
  output logic              ps_we_n,
  output logic              ps_ub_n,
  output logic              ps_lb_n
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n, idle, pwr_busy;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dmem_pwr u_pwr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .idle     (idle),
    .ps_sleep (ps_sleep),
    .fl_reset (fl_reset),
    .ps_ce2   (ps_ce2),
    .fl_rst_n (fl_rst_n),
    .busy     (pwr_busy)
  );

  dmem_seq #(.ADDR_W(ADDR_W), .FL_ACC(FL_ACC), .PS_ACC(PS_ACC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_tgt   (req_tgt),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .fl_up     (fl_rst_n),
    .ps_up     (ps_ce2),
    .pwr_busy  (pwr_busy),
    .idle      (idle),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_i  (mem_dq_i),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n),
    .fl_adv_n  (fl_adv_n),
    .ps_ce1_n  (ps_ce1_n),
    .ps_oe_n   (ps_oe_n),
    .ps_we_n   (ps_we_n),
    .ps_ub_n   (ps_ub_n),
    .ps_lb_n   (ps_lb_n)
  );
endmodule

// File: rtl/dmem_bus_ctrl_chk.sv
module dmem_bus_ctrl_chk #(
  parameter int ADDR_W = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [15:0]       rsp_rdata,
  input logic              rsp_err,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_dq_o,
  input logic              fl_ce_n,
  input logic              fl_oe_n,
  input logic              fl_we_n,
  input logic              fl_adv_n,
  input logic              fl_rst_n,
  input logic              ps_ce1_n,
  input logic              ps_ce2,
  input logic              ps_we_n,
  input logic              ps_ub_n,
  input logic              ps_lb_n
);
  AST_NO_ILLEGAL_COMBO: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_ce_n && !ps_ce1_n && ps_ce2)); // R1
  AST_FL_ENTRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_ce_n) |-> $past(ps_ce1_n)); // R1
  AST_PS_ENTRY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps_ce1_n) |-> $past(fl_ce_n)); // R1
  AST_PS_A22_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_ce1_n |-> !mem_addr[ADDR_W-1]); // R2
  AST_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ps_ce1_n |-> (ps_ub_n && ps_lb_n)); // R3
  AST_FL_LATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_ce_n) |-> !fl_adv_n); // R5
  AST_FL_LATCH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_oe_n || !fl_we_n) |-> fl_adv_n); // R5
  AST_FL_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (!fl_ce_n && $stable(mem_addr) && $stable(mem_dq_o))); // R6
  AST_PS_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps_we_n) |-> (!ps_ce1_n && $stable(mem_addr) && $stable(mem_dq_o))); // R6
  AST_SLEEP_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_ce2 |-> ps_ce1_n); // R7
  AST_FL_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_rst_n |-> (fl_ce_n && fl_oe_n && fl_we_n)); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R10
  AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && ps_ce1_n && !rsp_valid)); // R10
endmodule

bind dmem_bus_ctrl dmem_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .mem_addr  (mem_addr),
  .mem_dq_o  (mem_dq_o),
  .fl_ce_n   (fl_ce_n),
  .fl_oe_n   (fl_oe_n),
  .fl_we_n   (fl_we_n),
  .fl_adv_n  (fl_adv_n),
  .fl_rst_n  (fl_rst_n),
  .ps_ce1_n  (ps_ce1_n),
  .ps_ce2    (ps_ce2),
  .ps_we_n   (ps_we_n),
  .ps_ub_n   (ps_ub_n),
  .ps_lb_n   (ps_lb_n)
);

// File: tb/dmem_bus_ctrl_tb.sv
`timescale 1ns/1ps
module dmem_bus_ctrl_tb;
  localparam int AW = 23;
  localparam int FA = 3;
  localparam int PA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_tgt = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic rsp_ready = 1'b1, ps_sleep = 1'b0, fl_reset = 1'b0;
  logic req_ready, rsp_valid, rsp_err, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_adv_n, fl_rst_n;
  logic ps_ce1_n, ps_ce2, ps_oe_n, ps_we_n, ps_ub_n, ps_lb_n;

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  dmem_bus_ctrl #(.ADDR_W(AW), .FL_ACC(FA), .PS_ACC(PA)) u_dut (.*);

  // ---------------- bus models ----------------
  logic [15:0] fmem [64];
  logic [15:0] pmem [64];
  logic [15:0] ref_f [64];
  logic [15:0] ref_p [64];
  logic [AW-1:0] fl_lat = '0;
  int fl_oe_cnt = 0, ps_oe_cnt = 0, fl_oe_len = 0, ps_oe_len = 0;
  int combo_bad = 0, a22_bad = 0, fl_act = 0, ps_act = 0;
  logic prev_fl_we = 1'b1, prev_ps_we = 1'b1, prev_fl_oe = 1'b1, prev_ps_oe = 1'b1;

  function automatic int fidx(input logic [AW-1:0] a);
    return {26'd0, a[AW-1], a[4:0]};
  endfunction

  function automatic logic [15:0] ps_expect(input logic [15:0] w, input logic [1:0] be);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  always_comb begin
    mem_dq_i = 16'hDEAD;
    if (!fl_ce_n && !fl_oe_n && fl_oe_cnt >= FA) mem_dq_i = fmem[fidx(fl_lat)];
    else if (!ps_ce1_n && !ps_oe_n && ps_oe_cnt >= PA)
      mem_dq_i = {!ps_ub_n ? pmem[mem_addr[5:0]][15:8] : 8'hEE,
                  !ps_lb_n ? pmem[mem_addr[5:0]][7:0]  : 8'hEE};
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_ce_n && !ps_ce1_n && ps_ce2) combo_bad++;
      if (!ps_ce1_n && mem_addr[AW-1]) a22_bad++;
      if (!fl_ce_n) fl_act++;
      if (!ps_ce1_n) ps_act++;
      if (!fl_ce_n && !fl_adv_n) fl_lat = mem_addr;
      if (!fl_oe_n) fl_oe_cnt++;
      if (!ps_oe_n) ps_oe_cnt++;
      if (!prev_fl_oe && fl_oe_n) begin fl_oe_len = fl_oe_cnt; fl_oe_cnt = 0; end
      if (!prev_ps_oe && ps_oe_n) begin ps_oe_len = ps_oe_cnt; ps_oe_cnt = 0; end
      if (!prev_fl_we && fl_we_n && !fl_ce_n && mem_dq_oe) fmem[fidx(fl_lat)] = mem_dq_o;
      if (!prev_ps_we && ps_we_n && !ps_ce1_n && mem_dq_oe) begin
        if (!ps_ub_n) pmem[mem_addr[5:0]][15:8] = mem_dq_o[15:8];
        if (!ps_lb_n) pmem[mem_addr[5:0]][7:0]  = mem_dq_o[7:0];
      end
      prev_fl_we = fl_we_n; prev_ps_we = ps_we_n;
      prev_fl_oe = fl_oe_n; prev_ps_oe = ps_oe_n;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_req(input bit tgt, input bit wr, input logic [AW-1:0] a,
                        input logic [15:0] d, input logic [1:0] be, input int hold,
                        output logic [15:0] rd, output bit er);
    @(negedge clk);
    req_valid = 1'b1; req_tgt = tgt; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_ready = (hold == 0);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; er = rsp_err;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(rsp_valid && rsp_rdata == rd && rsp_err == er, "R10 response hold", {15'd0, rsp_valid, rsp_rdata}, {15'd1, rd});
      rsp_ready = 1'b1;
    end
    @(negedge clk);
    rsp_ready = 1'b1;
  endtask

  task automatic op(input bit tgt, input bit wr, input logic [AW-1:0] a,
                    input logic [15:0] d, input logic [1:0] be, input int hold);
    logic [15:0] rd, exp;
    bit er;
    do_req(tgt, wr, a, d, be, hold, rd, er);
    chk(!er, "R9 unexpected error", {31'd0, er}, 32'd0);
    if (wr) begin
      if (!tgt) ref_f[fidx(a)] = d;
      else begin
        if (be[1]) ref_p[a[5:0]][15:8] = d[15:8];
        if (be[0]) ref_p[a[5:0]][7:0]  = d[7:0];
      end
    end else begin
      exp = tgt ? ps_expect(ref_p[a[5:0]], be) : ref_f[fidx(a)];
      chk(rd == exp, tgt ? "R3/R4/R6 psram read data" : "R4/R5/R6 flash read data", {16'd0, rd}, {16'd0, exp});
      chk((tgt ? ps_oe_len : fl_oe_len) == (tgt ? PA : FA), "R4 output enable width",
          tgt ? ps_oe_len : fl_oe_len, tgt ? PA : FA);
    end
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] rd;
    bit er;
    int act0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      fmem[i] = 16'h1000 + 16'(i * 37); ref_f[i] = 16'h1000 + 16'(i * 37);
      pmem[i] = 16'h8000 + 16'(i * 91); ref_p[i] = 16'h8000 + 16'(i * 91);
    end
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(fl_ce_n && ps_ce1_n && fl_oe_n && fl_we_n && fl_adv_n && ps_oe_n && ps_we_n && ps_ub_n && ps_lb_n,
        "R11 strobes idle in reset", {31'd0, fl_ce_n}, 32'd1);
    chk(!rsp_valid && ps_ce2, "R11 response and sleep pin in reset", {30'd0, rsp_valid, ps_ce2}, 32'd1);
    chk(!fl_rst_n, "R8 flash reset low during reset", {31'd0, fl_rst_n}, 32'd0);
    chk(!req_ready, "R10 not ready in reset", {31'd0, req_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(fl_rst_n, "R8 flash reset released after idle", {31'd0, fl_rst_n}, 32'd1);

    // R2: bit 22 separates flash words, aliases for pseudo-SRAM
    op(1'b0, 1'b1, 23'h400003, 16'hA5A5, 2'b11, 0);
    op(1'b0, 1'b1, 23'h000003, 16'h5A5A, 2'b11, 0);
    op(1'b0, 0, 23'h400003, 16'h0, 2'b11, 0);
    op(1'b0, 0, 23'h000003, 16'h0, 2'b00, 0); // R3 flash ignores byte enables
    op(1'b1, 1'b1, 23'h400011, 16'hC3C3, 2'b11, 0);
    do_req(1'b1, 1'b0, 23'h000011, 16'h0, 2'b11, 0, rd, er);
    chk(rd == 16'hC3C3, "R2 psram aliases bit 22", {16'd0, rd}, 32'hC3C3);

    // R3 byte lanes
    op(1'b1, 1'b1, 23'h000020, 16'h1122, 2'b11, 0);
    op(1'b1, 1'b1, 23'h000020, 16'hAABB, 2'b01, 0);
    op(1'b1, 0, 23'h000020, 16'h0, 2'b11, 0);
    op(1'b1, 1'b1, 23'h000020, 16'hCCDD, 2'b10, 2);
    op(1'b1, 0, 23'h000020, 16'h0, 2'b10, 0);
    op(1'b1, 0, 23'h000020, 16'h0, 2'b01, 0);
    op(1'b1, 0, 23'h000020, 16'h0, 2'b00, 3);

    // random mix
    for (int n = 0; n < 400; n++) begin
      bit t, w;
      logic [AW-1:0] a;
      t = 1'($urandom());
      w = 1'($urandom());
      a = AW'($urandom());
      op(t, w, a, 16'($urandom()), 2'($urandom()), ($urandom() % 4 == 0) ? int'($urandom() % 4) : 0);
    end

    // R7 / R9 pseudo-SRAM sleep
    @(negedge clk);
    ps_sleep = 1'b1;
    #1;
    chk(!req_ready, "R10 ready low while pin change pending", {31'd0, req_ready}, 32'd0);
    repeat (2) @(negedge clk);
    chk(!ps_ce2 && ps_ce1_n, "R7 sleep pin low in standby", {30'd0, ps_ce2, ps_ce1_n}, 32'd1);
    act0 = ps_act;
    do_req(1'b1, 1'b0, 23'h000020, 16'h0, 2'b11, 0, rd, er);
    chk(er && rd == 16'h0, "R9 sleeping psram refused", {15'd0, er, rd}, 32'h10000);
    do_req(1'b1, 1'b1, 23'h000020, 16'hFFFF, 2'b11, 1, rd, er);
    chk(er && ps_act == act0, "R9 no psram bus cycle", ps_act, act0);
    op(1'b0, 1'b1, 23'h000007, 16'h7777, 2'b11, 0);
    op(1'b0, 0, 23'h000007, 16'h0, 2'b11, 0);
    ps_sleep = 1'b0;
    repeat (2) @(negedge clk);
    chk(ps_ce2, "R7 sleep pin restored", {31'd0, ps_ce2}, 32'd1);
    op(1'b1, 0, 23'h000020, 16'h0, 2'b11, 0);

    // R8 / R9 flash reset
    fl_reset = 1'b1;
    repeat (2) @(negedge clk);
    chk(!fl_rst_n, "R8 flash reset pin low on request", {31'd0, fl_rst_n}, 32'd0);
    act0 = fl_act;
    do_req(1'b0, 1'b0, 23'h000007, 16'h0, 2'b11, 0, rd, er);
    chk(er && rd == 16'h0 && fl_act == act0, "R9 flash in reset refused", {15'd0, er, rd}, 32'h10000);
    op(1'b1, 1'b1, 23'h000030, 16'h3131, 2'b11, 0);
    op(1'b1, 0, 23'h000030, 16'h0, 2'b11, 0);
    fl_reset = 1'b0;
    repeat (2) @(negedge clk);
    chk(fl_rst_n, "R8 flash reset released on request", {31'd0, fl_rst_n}, 32'd1);
    op(1'b0, 0, 23'h000007, 16'h0, 2'b11, 0);

    chk(combo_bad == 0, "R1 illegal enable combination", combo_bad, 0);
    chk(a22_bad == 0, "R2 bit 22 high on psram cycle", a22_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule